// File: doc/BRIEF.md
# System Clock Source Controller

This block holds the oscillator enables and the system clock source choice for a chip, written by software as one 32-bit control word at offset 0x004 of a small register bus. It drives enable outputs to an internal RC oscillator and an external crystal oscillator. It also drives a two-bit code that tells the clock multiplexer which source to use. The block does not take software's request as given. It refuses to turn off an oscillator the system clock depends on. It moves to a new source only once that source reports ready. A request for a source that is not yet ready waits until it is.

Two hardware paths override software. A stuck-clock monitor watches the external oscillator through a synchronizer. If no edge arrives within `TIMEOUT` reference cycles, it raises a sticky failure flag and forces the internal RC source. The RC source stays in use until software clears the flag and the crystal reports ready again. A fast-start option makes a power-save wakeup run from the RC source at first. The block then returns to the requested source by itself when that source signals ready.

Top module: `clk_ctl_top`

## Requirements
- R1: After reset, the control word at offset 0x004 reads 0x0000_0803, the effective source output is the RC code 2'b11, the RC enable output is 1 and the crystal enable output is 0.
- R2: Bit 17 (wake fast-start), bit 16 (monitor enable), bit 11 (RC enable), bit 10 (crystal enable) and bits [1:0] (source request) read back what was written. All other bits read 0, except bit 20. A read of any address other than 0x004 returns 0, and a write to any other address changes nothing.
- R3: A write that clears bit 11 is ignored while the RC source is the effective source or the pending target.
- R4: A write that clears bit 10 is ignored while the crystal is the effective source or the pending target, or while the PLL-input-select input is 1.
- R5: The source codes are 2'b11 for RC, 2'b10 for the crystal and 2'b01 for the PLL. A write whose bits [1:0] are 2'b00 leaves the stored request unchanged.
- R6: The effective source output changes only to a source that is ready. RC is ready when its ready input and bit 11 are both 1. The crystal is ready when its ready input and bit 10 are both 1. The PLL is ready when its ready input is 1. A request for a source that is not ready is held until that source becomes ready.
- R7: While bits 16 and 10 are both 1, a crystal input with no edge for `TIMEOUT` cycles sets the failure flag (bit 20) and forces the RC source. A crystal input that keeps toggling sets nothing.
- R8: The failure flag stays 1 until a 1 is written to bit 20. Writing 0 to bit 20 leaves it unchanged. The forced RC source stays in effect until the flag is clear and the crystal ready input is 1.
- R9: With bit 17 set, a wakeup pulse moves the effective source to RC until the requested source is ready, then returns to it with no write.
- R10: With bit 17 clear, a wakeup pulse has no effect on the effective source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| xtal_clk_in | input | 1 | External oscillator output, sampled for the stuck check |
| rc_ready | input | 1 | RC oscillator is stable |
| xtal_ready | input | 1 | Crystal oscillator is stable |
| pll_ready | input | 1 | PLL is locked |
| pll_src_xtal | input | 1 | PLL takes the crystal as its input |
| wake_pulse | input | 1 | One-cycle pulse on leaving power-save |
| rc_osc_en | output | 1 | RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| sys_src_sel | output | 2 | Effective system clock source code |
| clk_fail | output | 1 | Sticky crystal failure flag |

## Verification
A table of control words walks the source request through RC, crystal and PLL with all sources ready. Each row includes enable-clearing writes, so the table separates an accepted write from one the hardware guards refuse. Directed sequences then hold one ready input low. This shows a switch being held pending rather than taken early. The crystal input is run toggling and then frozen, which separates a healthy oscillator from a stuck one and tests that the flag only clears when software writes a 1. Wakeup pulses with the fast-start bit set and with it clear show whether the detour through RC happens and whether the block returns by itself.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_PLL  = 2'b01,
        SRC_XTAL = 2'b10,
        SRC_RC   = 2'b11
    } clk_src_e;

    localparam int BIT_FAIL  = 20;
    localparam int BIT_WAKE  = 17;
    localparam int BIT_MON   = 16;
    localparam int BIT_RCEN  = 11;
    localparam int BIT_XTEN  = 10;

    typedef struct packed {
        logic     wake_fast;
        logic     mon_en;
        logic     rc_en;
        logic     xtal_en;
        clk_src_e sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{wake_fast: 1'b0, mon_en: 1'b0, rc_en: 1'b1,
                                   xtal_en: 1'b0, sel: SRC_RC};

    function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic fail);
        logic [31:0] w;
        w           = '0;
        w[BIT_FAIL] = fail;
        w[BIT_WAKE] = c.wake_fast;
        w[BIT_MON]  = c.mon_en;
        w[BIT_RCEN] = c.rc_en;
        w[BIT_XTEN] = c.xtal_en;
        w[1:0]      = c.sel;
        return w;
    endfunction

    function automatic logic src_ready(input clk_src_e s, input logic rc_ok,
                                       input logic xt_ok, input logic pll_ok);
        case (s)
            SRC_PLL:  return pll_ok;
            SRC_XTAL: return xt_ok;
            default:  return rc_ok;
        endcase
    endfunction

endpackage

// File: rtl/clk_ctl_regs.sv
module clk_ctl_regs
    import clk_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              guard_rc,
    input  logic              guard_xtal,
    input  logic              fail_set,
    output ctrl_t             ctrl,
    output logic              fail_flag,
    output logic [31:0]       rdata
);

    logic  hit_wr;
    ctrl_t ctrl_d;
    logic  fail_d;
    logic  unused_wbits;

    assign hit_wr       = wr_en && (addr == CTRL_OFF);
    assign unused_wbits = ^{wdata[31:21], wdata[19:18], wdata[15:12], wdata[9:2]};

    always_comb begin
        ctrl_d = ctrl;
        fail_d = fail_flag;
        if (hit_wr) begin
            ctrl_d.wake_fast = wdata[BIT_WAKE];
            ctrl_d.mon_en    = wdata[BIT_MON];
            ctrl_d.rc_en     = wdata[BIT_RCEN] | (guard_rc & ctrl.rc_en);
            ctrl_d.xtal_en   = wdata[BIT_XTEN] | (guard_xtal & ctrl.xtal_en);
            if (wdata[1:0] != SRC_NONE)
                ctrl_d.sel = clk_src_e'(wdata[1:0]);
            if (wdata[BIT_FAIL])
                fail_d = 1'b0;
        end
        if (fail_set)
            fail_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RST;
            fail_flag <= 1'b0;
        end else begin
            ctrl      <= ctrl_d;
            fail_flag <= fail_d;
        end
    end

    assign rdata = (addr == CTRL_OFF) ? pack_ctrl(ctrl, fail_flag) : 32'h0;

endmodule

// File: rtl/clk_ctl_monitor.sv
module clk_ctl_monitor #(
    parameter int TIMEOUT = 16,
    parameter int SYNC_N  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic xtal_clk_in,
    output logic fail_set
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

    logic [SYNC_N:0]  sync_q;
    logic             edge_seen;
    logic [CNT_W-1:0] idle_cnt;

    genvar g;
    generate
        for (g = 0; g <= SYNC_N; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[g] <= 1'b0;
                else if (g == 0)
                    sync_q[g] <= xtal_clk_in;
                else
                    sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    assign edge_seen = sync_q[SYNC_N] ^ sync_q[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst || !enable || edge_seen)
            idle_cnt <= '0;
        else if (idle_cnt != LIMIT)
            idle_cnt <= idle_cnt + 1'b1;
    end

    assign fail_set = enable && !edge_seen && (idle_cnt == LAST);

endmodule

// File: rtl/clk_ctl_switch.sv
module clk_ctl_switch
    import clk_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctrl_t    ctrl,
    input  logic     fail_flag,
    input  logic     fail_set,
    input  logic     wake_pulse,
    input  logic     rc_ready,
    input  logic     xtal_ready,
    input  logic     pll_ready,
    input  logic     pll_src_xtal,
    output clk_src_e cur_src,
    output logic     guard_rc,
    output logic     guard_xtal
);

    logic     fallback_q;
    logic     wake_q;
    clk_src_e target;
    logic     rc_ok, xt_ok;
    logic     tgt_ok, req_ok;

    assign rc_ok  = rc_ready && ctrl.rc_en;
    assign xt_ok  = xtal_ready && ctrl.xtal_en;
    assign target = (fallback_q || wake_q) ? SRC_RC : ctrl.sel;
    assign tgt_ok = src_ready(target, rc_ok, xt_ok, pll_ready);
    assign req_ok = src_ready(ctrl.sel, rc_ok, xt_ok, pll_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_src    <= SRC_RC;
            fallback_q <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            if (tgt_ok)
                cur_src <= target;
            if (fail_set)
                fallback_q <= 1'b1;
            else if (!fail_flag && xtal_ready)
                fallback_q <= 1'b0;
            if (wake_pulse && ctrl.wake_fast)
                wake_q <= 1'b1;
            else if (req_ok)
                wake_q <= 1'b0;
        end
    end

    assign guard_rc   = (cur_src == SRC_RC) || (target == SRC_RC);
    assign guard_xtal = (cur_src == SRC_XTAL) || (target == SRC_XTAL) || pll_src_xtal;

endmodule

// File: rtl/clk_ctl_top.sv
module clk_ctl_top
    import clk_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h04,
    parameter int                TIMEOUT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              xtal_clk_in,
    input  logic              rc_ready,
    input  logic              xtal_ready,
    input  logic              pll_ready,
    input  logic              pll_src_xtal,
    input  logic              wake_pulse,
    output logic              rc_osc_en,
    output logic              xtal_osc_en,
    output logic [1:0]        sys_src_sel,
    output logic              clk_fail
);

    ctrl_t    ctrl;
    logic     fail_flag;
    logic     fail_set;
    logic     guard_rc, guard_xtal;
    clk_src_e cur_src;

    clk_ctl_regs #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wr_en      (bus_wr),
        .wdata      (bus_wdata),
        .guard_rc   (guard_rc),
        .guard_xtal (guard_xtal),
        .fail_set   (fail_set),
        .ctrl       (ctrl),
        .fail_flag  (fail_flag),
        .rdata      (bus_rdata)
    );

    clk_ctl_monitor #(.TIMEOUT(TIMEOUT), .SYNC_N(2)) mon_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (ctrl.mon_en && ctrl.xtal_en),
        .xtal_clk_in (xtal_clk_in),
        .fail_set    (fail_set)
    );

    clk_ctl_switch sw_i (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .fail_flag    (fail_flag),
        .fail_set     (fail_set),
        .wake_pulse   (wake_pulse),
        .rc_ready     (rc_ready),
        .xtal_ready   (xtal_ready),
        .pll_ready    (pll_ready),
        .pll_src_xtal (pll_src_xtal),
        .cur_src      (cur_src),
        .guard_rc     (guard_rc),
        .guard_xtal   (guard_xtal)
    );

    assign rc_osc_en   = ctrl.rc_en;
    assign xtal_osc_en = ctrl.xtal_en;
    assign sys_src_sel = cur_src;
    assign clk_fail    = fail_flag;

endmodule

// File: rtl/clk_ctl_sva.sv
module clk_ctl_sva #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h04
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        sys_src_sel,
    input logic              rc_osc_en,
    input logic              xtal_osc_en,
    input logic              rc_ready,
    input logic              xtal_ready,
    input logic              pll_ready,
    input logic              clk_fail
);

    AST_RC_HELD: assert property (@(posedge clk) disable iff (rst)
        (sys_src_sel == 2'b11) |-> rc_osc_en); // R3

    AST_XTAL_HELD: assert property (@(posedge clk) disable iff (rst)
        (sys_src_sel == 2'b10) |-> xtal_osc_en); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & 32'hFFEC_F3FC) == 32'h0); // R2

    AST_TO_XTAL_READY: assert property (@(posedge clk) disable iff (rst)
        (sys_src_sel == 2'b10 && $past(sys_src_sel) != 2'b10)
            |-> $past(xtal_ready && xtal_osc_en)); // R6

    AST_TO_PLL_READY: assert property (@(posedge clk) disable iff (rst)
        (sys_src_sel == 2'b01 && $past(sys_src_sel) != 2'b01) |-> $past(pll_ready)); // R6

    AST_TO_RC_READY: assert property (@(posedge clk) disable iff (rst)
        (sys_src_sel == 2'b11 && $past(sys_src_sel) != 2'b11)
            |-> $past(rc_ready && rc_osc_en)); // R6

    AST_FAIL_FORCES_RC: assert property (@(posedge clk) disable iff (rst)
        (clk_fail && rc_ready && rc_osc_en) |=> (sys_src_sel == 2'b11)); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (clk_fail && !(bus_wr && bus_addr == CTRL_OFF && bus_wdata[20])) |=> clk_fail); // R8

endmodule

bind clk_ctl_top clk_ctl_sva #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) sva_i (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_src_sel (sys_src_sel),
    .rc_osc_en   (rc_osc_en),
    .xtal_osc_en (xtal_osc_en),
    .rc_ready    (rc_ready),
    .xtal_ready  (xtal_ready),
    .pll_ready   (pll_ready),
    .clk_fail    (clk_fail)
);

// File: tb/clk_ctl_top_tb_top.sv
module clk_ctl_top_tb_top;

    localparam int ADDR_W = 8;
    localparam int NV     = 9;

    localparam logic [31:0] VEC_W [NV] = '{
        32'h0000_0C03, 32'h0000_0C02, 32'hFFFF_FFFC, 32'h0003_0402, 32'h0003_0002,
        32'h0000_0C01, 32'h0000_0801, 32'h0000_0803, 32'h0000_0003};
    localparam logic [31:0] VEC_R [NV] = '{
        32'h0000_0C03, 32'h0000_0C02, 32'h0003_0C02, 32'h0003_0402, 32'h0003_0402,
        32'h0000_0C01, 32'h0000_0801, 32'h0000_0803, 32'h0000_0803};
    localparam logic [1:0] VEC_S [NV] = '{
        2'b11, 2'b10, 2'b10, 2'b10, 2'b10, 2'b01, 2'b01, 2'b11, 2'b11};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = 8'h04;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              xtal_clk = 1'b0;
    logic              rc_ready = 1'b1, xtal_ready = 1'b1, pll_ready = 1'b1;
    logic              pll_src_xtal = 1'b0, wake_pulse = 1'b0;
    logic              rc_osc_en, xtal_osc_en, clk_fail;
    logic [1:0]        sys_src_sel;
    logic              xt_run = 1'b1;
    int                checks = 0, errors = 0;
    bit                done = 1'b0;

    always #5 clk = ~clk;

    clk_ctl_top #(.ADDR_W(ADDR_W), .CTRL_OFF(8'h04), .TIMEOUT(16)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal_clk_in(xtal_clk),
        .rc_ready(rc_ready), .xtal_ready(xtal_ready), .pll_ready(pll_ready),
        .pll_src_xtal(pll_src_xtal), .wake_pulse(wake_pulse),
        .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en),
        .sys_src_sel(sys_src_sel), .clk_fail(clk_fail));

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            if (xt_run) xtal_clk = ~xtal_clk;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h04;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 8'h04;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_pulse = 1'b1;
        @(negedge clk); wake_pulse = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, r);
        chk("R1 ctrl", r, 32'h0000_0803);
        chk("R1 src", {30'd0, sys_src_sel}, 32'd3);
        chk("R1 en", {30'd0, rc_osc_en, xtal_osc_en}, 32'd2);

        // table: R2 R3 R4 R5 readback and effective source
        for (int i = 0; i < NV; i++) begin
            wr(8'h04, VEC_W[i]);
            idle(3);
            rd(8'h04, r);
            chk($sformatf("R2/R5 vec%0d read", i), r, VEC_R[i]);
            chk($sformatf("R3/R4 vec%0d src", i), {30'd0, sys_src_sel}, {30'd0, VEC_S[i]});
        end

        // R2 other offsets
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, r);
        chk("R2 other addr read", r, 32'h0);
        rd(8'h04, r);
        chk("R2 other addr write", r, 32'h0000_0803);

        // R6 pending switch
        pll_ready = 1'b0;
        wr(8'h04, 32'h0000_0801);
        idle(5);
        chk("R6 held pending", {30'd0, sys_src_sel}, 32'd3);
        pll_ready = 1'b1;
        idle(3);
        chk("R6 taken when ready", {30'd0, sys_src_sel}, 32'd1);
        wr(8'h04, 32'h0000_0803);
        idle(3);

        // R4 PLL fed by crystal
        pll_src_xtal = 1'b1;
        wr(8'h04, 32'h0000_0C01);
        idle(3);
        wr(8'h04, 32'h0000_0801);
        rd(8'h04, r);
        chk("R4 pll input guard", r, 32'h0000_0C01);
        pll_src_xtal = 1'b0;

        // R7 monitor
        wr(8'h04, 32'h0001_0C02);
        idle(60);
        rd(8'h04, r);
        chk("R7 toggling no fail", r, 32'h0001_0C02);
        chk("R7 src xtal", {30'd0, sys_src_sel}, 32'd2);
        xt_run = 1'b0;
        idle(40);
        rd(8'h04, r);
        chk("R7 stuck flag", r, 32'h0011_0C02);
        chk("R7 forced rc", {30'd0, sys_src_sel}, 32'd3);

        // R8 sticky flag and release
        wr(8'h04, 32'h0001_0C02);
        rd(8'h04, r);
        chk("R8 write 0 keeps flag", r, 32'h0011_0C02);
        xt_run = 1'b1;
        xtal_ready = 1'b0;
        wr(8'h04, 32'h0011_0C02);
        idle(5);
        rd(8'h04, r);
        chk("R8 w1c", r, 32'h0001_0C02);
        chk("R8 held until ready", {30'd0, sys_src_sel}, 32'd3);
        xtal_ready = 1'b1;
        idle(5);
        chk("R8 released", {30'd0, sys_src_sel}, 32'd2);

        // R9 wake fast-start
        wr(8'h04, 32'h0002_0C02);
        xtal_ready = 1'b0;
        pulse_wake();
        idle(3);
        chk("R9 wake on rc", {30'd0, sys_src_sel}, 32'd3);
        rd(8'h04, r);
        chk("R9 request kept", r, 32'h0002_0C02);
        xtal_ready = 1'b1;
        idle(4);
        chk("R9 returns", {30'd0, sys_src_sel}, 32'd2);

        // R10 wake without fast-start
        wr(8'h04, 32'h0000_0C02);
        xtal_ready = 1'b0;
        pulse_wake();
        idle(3);
        chk("R10 no effect", {30'd0, sys_src_sel}, 32'd2);
        xtal_ready = 1'b1;
        idle(2);

        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", n);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule